// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a core's register file and a 64-bit data memory port. It takes a base and a displacement and adds them in its own adder to form the effective address. For a load, it picks the addressed byte, halfword, word or doubleword out of the returned memory doubleword. It can reverse the byte order of the value and widens byte and halfword results with either zeros or copies of the sign bit. For a store, it moves register data into the addressed byte lanes, optionally byte-reversed, and drives one write enable per lane.

The unit is a two-stage pipeline and accepts one request per clock. A request is taken with a valid/ready handshake. In the following cycle, the address stage drives the memory request. The memory returns its data one cycle later, and that data is formatted in the return stage and presented with a valid/ready handshake. An access that is not naturally aligned never reaches memory. It completes with an alignment-error flag instead.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base + req_disp` modulo 2^AW. `mem_addr` carries that address with bits [2:0] forced to zero.
- R2: `req_size` encodes the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The byte offset k = EA[2:0] numbers bytes big-endian, so offset k occupies bits [63-8k : 56-8k] of a memory doubleword. A load result is right-justified, with the byte at the lowest offset most significant.
- R3: When `req_signed` is 1, byte and halfword loads are sign-extended to 64 bits; when it is 0, they are zero-extended. Word loads always have zero upper 32 bits, and doubleword loads are never extended.
- R4: When `req_rev` is 1, the byte order is reversed within the access size, for both loads and stores. Reversing a byte access leaves it unchanged. For loads, the reversal is applied before extension.
- R5: A store asserts `mem_we`. The byte at offset k+i is enabled by `mem_be[7-k-i]`. `mem_wdata` holds the data in those lanes and zero in all other lanes. A load drives `mem_be` to zero.
- R6: If the effective address is not a multiple of the access size, `mem_valid` stays low for that request. Its response carries `rsp_misalign` = 1 and `rsp_data` = 0.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_store` and `rsp_misalign` hold their values.
- R8: When the output is not stalled, a load accepted at clock edge t has its memory request in the cycle after t and its response valid two cycles after t. Requests are accepted back to back, one per cycle.
- R9: A store also returns a response, with `rsp_store` = 1 and `rsp_data` = 0. Responses leave in request order.
- R10: After reset, `rsp_valid` and `mem_valid` are low, and `req_ready` is high whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_rev | input | 1 | Reverse byte order of the access |
| req_base | input | AW | Address base operand |
| req_disp | input | AW | Address displacement operand |
| req_wdata | input | 64 | Store data, right-justified |
| mem_valid | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Doubleword-aligned memory address |
| mem_be | output | 8 | Per-lane write enables |
| mem_wdata | output | 64 | Lane-placed write data |
| mem_rdata | input | 64 | Read data, one cycle after the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_data | output | 64 | Formatted load result |
| rsp_misalign | output | 1 | Alignment error |
| rsp_store | output | 1 | Response belongs to a store |

## Verification
Several properties are checked on every cycle. A stalled response must not change. A load request must be followed by a response on the next cycle. Write enables must cover 1, 2, 4 or 8 lanes, and loads must enable none. Misaligned and store responses must carry zero data, and the unit must be ready whenever the output is empty. Only the bench's scenarios can show that the correct bytes are chosen, reversed and extended for each size and offset. The same holds for the effective-address wrap, for store lanes followed by a read-back, and for in-order delivery under random stalls.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic          req_rev,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_disp,
  input  logic [63:0]   req_wdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_be,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [63:0]   rsp_data,
  output logic          rsp_misalign,
  output logic          rsp_store
);

  function automatic logic [63:0] rev8(input logic [63:0] x);
    for (int i = 0; i < 8; i++) rev8[8*i +: 8] = x[8*(7-i) +: 8];
  endfunction

  // address stage
  logic          a_valid, a_st, a_sgn, a_rev;
  logic [1:0]    a_size;
  logic [AW-1:0] a_ea;
  logic [63:0]   a_wdata;
  // return stage
  logic          b_valid, b_fresh, b_st, b_sgn, b_rev, b_mis;
  logic [1:0]    b_size;
  logic [2:0]    b_off;
  logic [63:0]   b_hold;

  wire b_free = ~b_valid | rsp_ready;
  wire a_go   = a_valid & b_free;
  assign req_ready = ~a_valid | b_free;

  wire [AW-1:0] ea = req_base + req_disp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         a_valid <= 1'b0;
    else if (req_ready) a_valid <= req_valid;

  always_ff @(posedge clk)
    if (req_ready && req_valid) begin
      a_ea    <= ea;
      a_st    <= req_store;
      a_size  <= req_size;
      a_sgn   <= req_signed;
      a_rev   <= req_rev;
      a_wdata <= req_wdata;
    end

  wire [2:0] a_off  = a_ea[2:0];
  wire [6:0] a_sh   = 7'd64 - (7'd8 << a_size);
  wire       a_mis  = |(a_off & ~(3'b111 << a_size));
  wire [3:0] a_nb   = 4'd1 << a_size;
  wire [7:0] a_hi   = 8'hFF >> a_nb;
  wire [63:0] st_fld = a_wdata & ({64{1'b1}} >> a_sh);
  wire [63:0] st_val = a_rev ? (rev8(st_fld) >> a_sh) : st_fld;
  wire [63:0] st_pos = (st_val << a_sh) >> {a_off, 3'b000};

  assign mem_valid = a_go & ~a_mis;
  assign mem_we    = a_st;
  assign mem_addr  = {a_ea[AW-1:3], 3'b000};
  assign mem_be    = a_st ? (~a_hi >> a_off) : 8'h00;
  assign mem_wdata = a_st ? st_pos : 64'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_fresh <= 1'b0;
    end else begin
      if (b_free) b_valid <= a_valid;
      b_fresh <= a_go;
    end

  always_ff @(posedge clk) begin
    if (a_go) begin
      b_st   <= a_st;
      b_sgn  <= a_sgn;
      b_rev  <= a_rev;
      b_mis  <= a_mis;
      b_size <= a_size;
      b_off  <= a_off;
    end
    if (b_fresh) b_hold <= mem_rdata;
  end

  wire [63:0] ld_src = b_fresh ? mem_rdata : b_hold;
  wire [6:0]  b_sh   = 7'd64 - (7'd8 << b_size);
  wire [63:0] ld_fld = (ld_src << {b_off, 3'b000}) >> b_sh;
  wire [63:0] ld_rv  = b_rev ? (rev8(ld_fld) >> b_sh) : ld_fld;
  logic [63:0] ld_out;

  always_comb
    case (b_size)
      2'd0:    ld_out = {{56{b_sgn & ld_rv[7]}},  ld_rv[7:0]};
      2'd1:    ld_out = {{48{b_sgn & ld_rv[15]}}, ld_rv[15:0]};
      default: ld_out = ld_rv;
    endcase

  assign rsp_valid    = b_valid;
  assign rsp_store    = b_st;
  assign rsp_misalign = b_mis;
  assign rsp_data     = (b_st | b_mis) ? 64'd0 : ld_out;

endmodule

module lsu_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_we,
  input logic [7:0]  mem_be,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_data,
  input logic        rsp_misalign,
  input logic        rsp_store
);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
                                $stable(rsp_store) && $stable(rsp_misalign));

  a_r8_load_next_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |=> rsp_valid);

  a_r5_store_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> $countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                            $countones(mem_be) == 4 || $countones(mem_be) == 8);

  a_r5_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |-> mem_be == 8'h00);

  a_r6_misalign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misalign |-> rsp_data == 64'd0);

  a_r9_store_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_store |-> rsp_data == 64'd0);

  a_r10_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

endmodule

bind lsu_align lsu_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_be(mem_be),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_misalign(rsp_misalign), .rsp_store(rsp_store)
);

// File: tb/lsu_align_tb.sv
module lsu_align_tb_top;
  localparam int AW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_signed = 0, req_rev = 0, rsp_ready = 1;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_base = 0, req_disp = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, mem_valid, mem_we, rsp_valid, rsp_misalign, rsp_store;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_be;
  logic [63:0] mem_wdata, mem_rdata, rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align #(.AW(AW)) dut_i (.*);

  function automatic logic [63:0] init_dw(input int i);
    return 64'h8091_A2B3_C4D5_E6F7 ^ (64'h1357_0246_1357_0246 * 64'(i));
  endfunction

  logic [63:0] bmem [8];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bmem[i] <= init_dw(i);
      mem_rdata <= 64'd0;
    end else if (mem_valid) begin
      if (mem_we) begin
        for (int i = 0; i < 8; i++)
          if (mem_be[i]) bmem[mem_addr[5:3]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else mem_rdata <= bmem[mem_addr[5:3]];
    end

  logic [63:0] smem [8];
  int checks = 0, errors = 0, cyc = 0;
  bit lat_mode = 0;
  logic [63:0] q_data[$], q_mwd[$];
  logic q_mis[$], q_st[$], q_mwe[$];
  logic [7:0] q_be[$];
  logic [AW-1:0] q_addr[$];
  int q_cyc[$];
  bit stalled = 0;
  logic [63:0] st_data;
  logic st_mis, st_st;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model(input logic st, input logic [1:0] sz, input logic sg, input logic rv,
                       input logic [AW-1:0] ea, input logic [63:0] wd);
    int n = 1 << sz;
    int k = int'(ea[2:0]);
    logic [63:0] val = 0, pos = 0;
    logic [7:0] be = 0;
    bit mis = (k % n) != 0;
    if (!mis && st) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = rv ? wd[8*i +: 8] : wd[8*(n-1-i) +: 8];
        smem[ea[5:3]][8*(7-k-i) +: 8] = b;
        pos[8*(7-k-i) +: 8] = b;
        be[7-k-i] = 1'b1;
      end
    end else if (!mis) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = smem[ea[5:3]][8*(7-k-i) +: 8];
        if (rv) val[8*i +: 8] = b; else val[8*(n-1-i) +: 8] = b;
      end
      if (sg && n < 4 && val[8*n-1])
        for (int j = 8*n; j < 64; j++) val[j] = 1'b1;
    end
    if (!mis) begin
      q_addr.push_back({ea[AW-1:3], 3'b000});
      q_mwe.push_back(st); q_be.push_back(be); q_mwd.push_back(pos);
    end
    q_data.push_back(val); q_mis.push_back(mis); q_st.push_back(st); q_cyc.push_back(cyc);
  endtask

  task automatic step(input logic v, input logic st, input logic [1:0] sz, input logic sg,
                      input logic rv, input logic [AW-1:0] ea, input logic [AW-1:0] disp,
                      input logic [63:0] wd, input logic rdy);
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_signed = sg; req_rev = rv;
    req_disp = disp; req_base = ea - disp; req_wdata = wd; rsp_ready = rdy;
    #(CLK_PERIOD/2 - 1);
    if (stalled) chk(rsp_valid && rsp_data == st_data && rsp_misalign == st_mis && rsp_store == st_st,
                     "R7 stall hold", rsp_data, st_data);
    stalled = rsp_valid && !rsp_ready;
    st_data = rsp_data; st_mis = rsp_misalign; st_st = rsp_store;
    if (mem_valid) begin
      if (q_addr.size() == 0) chk(0, "R6 unexpected mem request", 64'(mem_addr), 0);
      else begin
        logic [AW-1:0] ad = q_addr.pop_front();
        logic we = q_mwe.pop_front();
        logic [7:0] be = q_be.pop_front();
        logic [63:0] mw = q_mwd.pop_front();
        chk(mem_addr == ad, "R1 mem_addr", 64'(mem_addr), 64'(ad));
        chk(mem_we == we, "R5 mem_we", 64'(mem_we), 64'(we));
        chk(mem_be == be, "R5 mem_be", 64'(mem_be), 64'(be));
        if (we) chk(mem_wdata == mw, "R4 R5 mem_wdata", mem_wdata, mw);
      end
    end
    if (rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) chk(0, "R9 unexpected response", rsp_data, 0);
      else begin
        logic [63:0] d = q_data.pop_front();
        logic m = q_mis.pop_front();
        logic s = q_st.pop_front();
        int c = q_cyc.pop_front();
        chk(rsp_misalign == m, "R6 misalign flag", 64'(rsp_misalign), 64'(m));
        chk(rsp_store == s, "R9 store flag", 64'(rsp_store), 64'(s));
        chk(rsp_data == d, "R2 R3 R4 load data", rsp_data, d);
        if (lat_mode) chk(cyc - c == 2, "R8 latency", 64'(cyc - c), 64'd2);
      end
    end
    if (req_valid && req_ready) model(st, sz, sg, rv, ea, wd);
    if (lat_mode && req_valid) chk(req_ready, "R8 back-to-back accept", 64'(req_ready), 64'd1);
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(q_data.size() == 0, "R9 all responses delivered", 64'(q_data.size()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 1000 * 150);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) smem[i] = init_dw(i);
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3 + 2);
    chk(!rsp_valid && !mem_valid, "R10 reset outputs", {62'd0, rsp_valid, mem_valid}, 0);
    rst_n = 1'b1;
    #(CLK_PERIOD/2);
    chk(req_ready, "R10 ready after reset", 64'(req_ready), 1);

    lat_mode = 1;
    step(1, 0, 0, 1, 0, 32'h0, 32'h0, 0, 1);              // R3 signed byte 0x80
    step(1, 0, 0, 0, 0, 32'h0, 32'h4, 0, 1);              // R3 unsigned byte
    step(1, 0, 1, 1, 0, 32'h2, 32'h1, 0, 1);              // R2 halfword offset 2
    step(1, 0, 0, 1, 1, 32'h5, 32'h5, 0, 1);              // R4 reversed byte unchanged
    step(1, 0, 2, 1, 0, 32'h0, 32'h0, 0, 1);              // R3 word not extended
    step(1, 0, 2, 0, 1, 32'h4, 32'h0, 0, 1);              // R4 reversed word
    step(1, 0, 3, 0, 1, 32'h8, 32'hFFFF_FFF8, 0, 1);      // R1 wrap, R4 dword rev
    step(1, 0, 1, 0, 0, 32'h1, 32'h0, 0, 1);              // R6 misaligned half
    step(1, 1, 2, 0, 0, 32'h12, 32'h0, 64'h1, 1);         // R6 misaligned word store
    step(1, 1, 1, 0, 1, 32'h6, 32'h0, 64'h1234, 1);       // R4 R5 reversed half store
    step(1, 0, 1, 0, 0, 32'h6, 32'h0, 0, 1);              // read back
    step(1, 1, 3, 0, 0, 32'h38, 32'h10, 64'hFEDC_BA98_7654_3210, 1); // R5 dword store
    step(1, 0, 3, 0, 0, 32'h38, 32'h0, 0, 1);
    step(1, 1, 0, 0, 0, 32'h3B, 32'h0, 64'hA5, 1);        // R5 byte store offset 3
    step(1, 0, 2, 1, 0, 32'h38, 32'h0, 0, 1);
    drain();
    lat_mode = 0;

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic [5:0] ea = 6'($urandom);
      if ($urandom_range(0, 9) != 0) ea = ea & ~6'((1 << sz) - 1);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 9) < 3, sz, 1'($urandom), 1'($urandom),
           {26'd0, ea}, $urandom, {$urandom, $urandom}, $urandom_range(0, 9) < 7);
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule